// File: doc/BRIEF.md
# Trip Threshold Programming Sequencer

This block sits beside the serial memory slave of a supply supervisor and turns one special memory write into a threshold-adjust request for one of the two voltage comparators. It looks at each completed single-byte write, and the device select, word address and data that came with it. When the reset pin is held at the programming voltage, the write goes to device select D8h, word address zero, and the byte is one of four special codes, the block arms the matching operation. The stop condition that closes that transaction starts the operation. One strobe then stays high until the reset pin is pulled low, which ends the operation.

The four strobes raise the primary trip level, raise the secondary trip level, return the primary trip level to its native low value, or return the secondary trip level to its native low value. The analog trimming, the high-voltage detector and the normal storage of the code byte at address zero are outside this block. The memory slave always stores the byte in the usual way. A busy output shows that an operation is in progress. While it is high, the block ignores new writes and stop conditions.

Top module: `trip_prog_seq`

## Requirements
- R1: After reset, all four strobes and `busy` are low and no operation is armed.
- R2: A completed write (`wr_done` high for one cycle) arms an operation when `hv_present` is high, `wr_dev` is 8'hD8 and `wr_addr` is 0. The data byte picks the operation: 8'h01 raises the primary trip, 8'h0D raises the secondary trip, 8'h03 returns the primary trip to native and 8'h0F returns the secondary trip to native.
- R3: When `stop_evt` is high while an operation is armed and `hv_present` is high, the strobe for that operation and `busy` go high one clock later. The arming is then used up.
- R4: While `busy` is high and `rst_pin_lvl` stays high, the active strobe and `busy` hold their values.
- R5: When `rst_pin_lvl` is low while `busy` is high, all strobes and `busy` are low one clock later.
- R6: A completed write with any other data byte, any other address, any other device select, or `hv_present` low arms nothing. It also removes any earlier arming, so a following stop raises no strobe.
- R7: While `busy` is high, completed writes and stop events are ignored. The active strobe stays unchanged, and after completion no operation is armed.
- R8: A stop event that arrives while armed but with `hv_present` low starts nothing and removes the arming.
- R9: At most one of the four strobes is high at any time.
- R10: When a stop event and a completed write occur in the same cycle, the stop acts on the earlier arming and the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hv_present | input | 1 | Reset pin is held at the programming voltage |
| wr_done | input | 1 | One-cycle pulse: a write byte has completed |
| wr_dev | input | 8 | Device select byte of that transaction |
| wr_addr | input | ADDR_W (13) | Word address of the completed write |
| wr_data | input | 8 | Data byte of the completed write |
| stop_evt | input | 1 | One-cycle pulse: stop condition seen on the bus |
| rst_pin_lvl | input | 1 | Sensed level of the reset pin (low = pulled low) |
| trip_set_pri | output | 1 | Raise primary trip level, held while active |
| trip_set_sec | output | 1 | Raise secondary trip level, held while active |
| trip_clr_pri | output | 1 | Return primary trip to native, held while active |
| trip_clr_sec | output | 1 | Return secondary trip to native, held while active |
| busy | output | 1 | A threshold operation is in progress |

## Verification
An armed code that is wrong or stale shows up at the ports only one cycle after the next stop. In that case the wrong strobe rises, or no strobe rises at all. So each case pairs an arming write with a stop, and the bench compares the outputs on every clock. A corrupted active state shows at once as a strobe that changes or drops while the reset pin stays high. An exit that is missing or late shows as `busy` still high one cycle after the pin goes low. The cycle-by-cycle reference model covers all of these.

// File: rtl/trip_prog_pkg.sv
package trip_prog_pkg;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_SET_PRI = 3'd1,
    OP_SET_SEC = 3'd2,
    OP_CLR_PRI = 3'd3,
    OP_CLR_SEC = 3'd4
  } trip_op_e;

  localparam int unsigned NUM_OPS = 4;

  // Map a data byte to the threshold operation it requests.
  function automatic trip_op_e code_to_op(input logic [7:0] code);
    trip_op_e op;
    case (code)
      8'h01:   op = OP_SET_PRI;
      8'h0D:   op = OP_SET_SEC;
      8'h03:   op = OP_CLR_PRI;
      8'h0F:   op = OP_CLR_SEC;
      default: op = OP_NONE;
    endcase
    return op;
  endfunction

endpackage

// File: rtl/trip_prog_qualify.sv
module trip_prog_qualify
  import trip_prog_pkg::*;
#(
  parameter int unsigned ADDR_W      = 13,
  parameter logic [7:0]  DEV_SEL     = 8'hD8,
  parameter int unsigned TARGET_ADDR = 0
) (
  input  logic              hv_present,
  input  logic [7:0]        wr_dev,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output trip_op_e          qual_op
);
  localparam logic [ADDR_W-1:0] TGT = ADDR_W'(TARGET_ADDR);

  logic dev_match;
  logic addr_match;

  assign dev_match  = (wr_dev == DEV_SEL);
  assign addr_match = (wr_addr == TGT);

  always_comb begin
    if (hv_present && dev_match && addr_match) qual_op = code_to_op(wr_data);
    else                                       qual_op = OP_NONE;
  end

endmodule

// File: rtl/trip_prog_fsm.sv
module trip_prog_fsm
  import trip_prog_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     hv_present,
  input  logic     wr_done,
  input  trip_op_e qual_op,
  input  logic     stop_evt,
  input  logic     rst_pin_lvl,
  output trip_op_e act_op,
  output logic     busy
);
  trip_op_e armed_q;
  trip_op_e act_q;

  // Named internal events for the checks below.
  logic idle;
  logic start_evt;
  logic finish_evt;
  logic arm_evt;

  assign idle       = (act_q == OP_NONE);
  assign start_evt  = idle && stop_evt && hv_present && (armed_q != OP_NONE);
  assign finish_evt = !idle && !rst_pin_lvl;
  assign arm_evt    = idle && !stop_evt && wr_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= OP_NONE;
      act_q   <= OP_NONE;
    end else if (!idle) begin
      if (finish_evt) act_q <= OP_NONE;
    end else if (stop_evt) begin
      if (start_evt) act_q <= armed_q;
      armed_q <= OP_NONE;
    end else if (arm_evt) begin
      armed_q <= qual_op;
    end
  end

  assign act_op = act_q;
  assign busy   = !idle;

  // R3: a stop while armed with the programming voltage starts the operation
  a_r3_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (busy && act_op == $past(armed_q)));

  // R4 / R7: held unchanged while the reset pin stays high
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rst_pin_lvl) |=> (busy && $stable(act_op)));

  // R5: pulling the reset pin low ends the operation
  a_r5_finish: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rst_pin_lvl) |=> !busy);

  // R3 / R8: busy only ever rises after a stop with the programming voltage
  a_r8_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(stop_evt) && $past(hv_present)));

  // R7: nothing is left armed when an operation completes
  a_r7_clean_exit: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (armed_q == OP_NONE));

endmodule

// File: rtl/trip_prog_strobe.sv
module trip_prog_strobe
  import trip_prog_pkg::*;
(
  input  trip_op_e             act_op,
  output logic [NUM_OPS-1:0]   strobe
);
  for (genvar i = 0; i < NUM_OPS; i++) begin : g_strobe
    assign strobe[i] = (act_op == trip_op_e'(i + 1));
  end
endmodule

// File: rtl/trip_prog_seq.sv
module trip_prog_seq
  import trip_prog_pkg::*;
#(
  parameter int unsigned ADDR_W      = 13,
  parameter logic [7:0]  DEV_SEL     = 8'hD8,
  parameter int unsigned TARGET_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hv_present,
  input  logic              wr_done,
  input  logic [7:0]        wr_dev,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              stop_evt,
  input  logic              rst_pin_lvl,
  output logic              trip_set_pri,
  output logic              trip_set_sec,
  output logic              trip_clr_pri,
  output logic              trip_clr_sec,
  output logic              busy
);
  trip_op_e             qual_op;
  trip_op_e             act_op;
  logic [NUM_OPS-1:0]   strobe;

  trip_prog_qualify #(
    .ADDR_W      (ADDR_W),
    .DEV_SEL     (DEV_SEL),
    .TARGET_ADDR (TARGET_ADDR)
  ) u_qualify (
    .hv_present (hv_present),
    .wr_dev     (wr_dev),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .qual_op    (qual_op)
  );

  trip_prog_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .hv_present  (hv_present),
    .wr_done     (wr_done),
    .qual_op     (qual_op),
    .stop_evt    (stop_evt),
    .rst_pin_lvl (rst_pin_lvl),
    .act_op      (act_op),
    .busy        (busy)
  );

  trip_prog_strobe u_strobe (
    .act_op (act_op),
    .strobe (strobe)
  );

  assign trip_set_pri = strobe[0];
  assign trip_set_sec = strobe[1];
  assign trip_clr_pri = strobe[2];
  assign trip_clr_sec = strobe[3];

  // R9: never more than one threshold strobe at a time
  a_r9_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trip_clr_sec, trip_clr_pri, trip_set_sec, trip_set_pri}));

  // R4: busy and the strobes agree
  a_r4_busy_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (trip_set_pri | trip_set_sec | trip_clr_pri | trip_clr_sec));

endmodule

// File: tb/trip_prog_seq_tb.sv
module trip_prog_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 13;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              hv_present = 1'b0;
  logic              wr_done = 1'b0;
  logic [7:0]        wr_dev = 8'h00;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [7:0]        wr_data = 8'h00;
  logic              stop_evt = 1'b0;
  logic              rst_pin_lvl = 1'b1;
  logic              trip_set_pri, trip_set_sec, trip_clr_pri, trip_clr_sec, busy;

  int n_cmp = 0;
  int n_bad = 0;
  int ref_armed = -1;   // -1: nothing armed, else strobe index
  int ref_act   = -1;   // -1: idle, else strobe index
  bit finished  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trip_prog_seq #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .hv_present(hv_present), .wr_done(wr_done),
    .wr_dev(wr_dev), .wr_addr(wr_addr), .wr_data(wr_data), .stop_evt(stop_evt),
    .rst_pin_lvl(rst_pin_lvl), .trip_set_pri(trip_set_pri), .trip_set_sec(trip_set_sec),
    .trip_clr_pri(trip_clr_pri), .trip_clr_sec(trip_clr_sec), .busy(busy)
  );

  function automatic int code_index(input logic [7:0] d);
    if (d == 8'h01) return 0;
    if (d == 8'h0D) return 1;
    if (d == 8'h03) return 2;
    if (d == 8'h0F) return 3;
    return -1;
  endfunction

  task automatic compare(input string tag);
    logic [3:0] got, exp;
    logic       exp_busy;
    got      = {trip_clr_sec, trip_clr_pri, trip_set_sec, trip_set_pri};
    exp      = (ref_act >= 0) ? 4'(1 << ref_act) : 4'b0000;
    exp_busy = (ref_act >= 0);
    n_cmp++;
    if (got !== exp || busy !== exp_busy) begin
      n_bad++;
      $display("FAIL %s: strobes=%b busy=%b expected strobes=%b busy=%b at %0t",
               tag, got, busy, exp, exp_busy, $time);
    end
  endtask

  // Advance one clock with the present inputs, update the model, compare.
  task automatic step(input string tag);
    if (ref_act >= 0) begin
      if (!rst_pin_lvl) ref_act = -1;
    end else if (stop_evt) begin
      if (ref_armed >= 0 && hv_present) ref_act = ref_armed;
      ref_armed = -1;
    end else if (wr_done) begin
      if (hv_present && wr_dev == 8'hD8 && wr_addr == 0) ref_armed = code_index(wr_data);
      else ref_armed = -1;
    end
    @(posedge clk);
    #2;
    wr_done  = 1'b0;
    stop_evt = 1'b0;
    compare(tag);
  endtask

  task automatic do_write(input logic [7:0] dev, input int addr, input logic [7:0] data,
                          input string tag);
    wr_done = 1'b1; wr_dev = dev; wr_addr = ADDR_W'(addr); wr_data = data;
    step(tag);
  endtask

  task automatic do_stop(input string tag);
    stop_evt = 1'b1;
    step(tag);
  endtask

  task automatic finish_op(input string tag);
    rst_pin_lvl = 1'b0;
    step(tag);
    step(tag);
    rst_pin_lvl = 1'b1;
    step(tag);
  endtask

  task automatic idle_cycles(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    report();
  end

  initial begin
    logic [7:0] codes [4];
    codes[0] = 8'h01; codes[1] = 8'h0D; codes[2] = 8'h03; codes[3] = 8'h0F;

    // R1: reset state
    repeat (3) @(posedge clk);
    #2;
    compare("R1 in reset");
    rst_n = 1'b1;
    idle_cycles(2, "R1 after reset");
    do_stop("R1 stop with nothing armed");

    // R2 R3 R4 R5: each code, start, hold, finish
    hv_present = 1'b1;
    for (int k = 0; k < 4; k++) begin
      do_write(8'hD8, 0, codes[k], "R2 arm");
      idle_cycles(1, "R2 armed wait");
      do_stop("R3 start");
      idle_cycles(4, "R4 hold");
      finish_op("R5 finish");
    end

    // R6: non-qualifying writes
    do_write(8'hD8, 0, 8'h02, "R6 other data");
    do_stop("R6 no strobe data");
    do_write(8'hD8, 1, 8'h01, "R6 other addr");
    do_stop("R6 no strobe addr");
    do_write(8'hD0, 0, 8'h01, "R6 other dev");
    do_stop("R6 no strobe dev");
    hv_present = 1'b0;
    do_write(8'hD8, 0, 8'h0D, "R6 no hv");
    hv_present = 1'b1;
    do_stop("R6 no strobe hv");
    do_write(8'hD8, 0, 8'h03, "R6 arm then spoil");
    do_write(8'hD8, 0, 8'h55, "R6 spoil");
    do_stop("R6 disarmed");

    // R7: ignored while busy
    do_write(8'hD8, 0, 8'h0D, "R7 arm");
    do_stop("R7 start");
    do_write(8'hD8, 0, 8'h01, "R7 write while busy");
    do_stop("R7 stop while busy");
    idle_cycles(2, "R7 hold");
    finish_op("R7 finish");
    do_stop("R7 nothing left armed");
    idle_cycles(1, "R7 idle");

    // R8: stop without programming voltage
    do_write(8'hD8, 0, 8'h0F, "R8 arm");
    hv_present = 1'b0;
    do_stop("R8 stop no hv");
    hv_present = 1'b1;
    do_stop("R8 later stop");
    idle_cycles(1, "R8 idle");

    // R10: stop and write in the same cycle
    do_write(8'hD8, 0, 8'h01, "R10 arm");
    stop_evt = 1'b1;
    wr_done = 1'b1; wr_dev = 8'hD8; wr_addr = '0; wr_data = 8'h0F;
    step("R10 stop wins");
    idle_cycles(2, "R10 hold");
    finish_op("R10 finish");

    // R9: back-to-back operations, one strobe at a time
    for (int k = 3; k >= 0; k--) begin
      do_write(8'hD8, 0, codes[k], "R9 arm");
      do_stop("R9 start");
      rst_pin_lvl = 1'b0;
      step("R9 finish");
      rst_pin_lvl = 1'b1;
    end
    idle_cycles(3, "R9 idle");

    report();
  end

endmodule